// File: doc/BRIEF.md
# Synchronous Burst Data Sender

This block pushes a burst of bytes from a target to an initiator in synchronous transfer mode. The bytes do not get a handshake each. Each byte goes onto the 8-bit bus with the request strobe raised, and the strobe then drops. The receiver latches the byte on that falling request edge. The sender does not wait for each acknowledge. It keeps a running count of acknowledges still owed and stalls only when one more byte would take the number of unacknowledged bytes past the negotiated offset.

A transfer begins with a one-cycle `start` that carries the length, the negotiated period (in 4 ns units) and the negotiated offset. Bytes arrive on a valid/ready stream. `s_ready` depends only on the block's own state, the acknowledge count and `bus_rst`, never on `s_valid`. A byte moves when both signals are high at a rising clock edge. The source may hold `s_valid` low for any number of cycles, and the block then simply waits. `s_data` must hold steady while `s_valid` is high and `s_ready` is low.

After the last byte the bus is held for one more half-period and then released. The block reports completion only once every acknowledge has come back. A bus reset abandons the transfer at once. The acknowledges still owed then stay readable on `ack_left`.

Top module: `sync_burst_tx`

## Requirements
- R1: A byte is driven on `bus_data` with `data_oe` high in the same cycle that `req_out` rises. `bus_data` stays unchanged while `req_out` is high. `data_oe` is high whenever `req_out` is high.
- R2: `ack_left` loads the transfer length on an accepted `start`. It then drops by exactly one for each high-to-low transition of `ack_in`, seen after a two-flop synchronizer, and it never goes below zero.
- R3: A byte is accepted only if `ack_left` is at most the number of bytes left to send after it plus the offset. The number of unacknowledged bytes therefore never exceeds the offset. An offset of 0 behaves as 1.
- R4: With H = max(1, ceil(2*period ns / CLK_NS)), `req_out` stays high for exactly H cycles. It stays low for at least H cycles, and for exactly H cycles when the next byte and credit are both ready.
- R5: After the last byte's request falls, `data_oe` stays high for 2*H cycles (its low phase plus one more half-period) and then drops to 0, with `bus_data` returning to 0.
- R6: `done` is a single-cycle pulse. It comes only after every byte has been sent and `ack_left` has reached 0, and `busy` is low afterwards.
- R7: `bus_rst` high while `busy` sends the block to idle at the next edge. `req_out` and `data_oe` go low and `aborted` is set, with no `done`. `ack_left` keeps its residual value, and `aborted` stays set until the next accepted `start`.
- R8: `s_ready` does not depend on `s_valid`. Bytes go out on the bus in the order they were accepted, and gaps in `s_valid` only delay them.
- R9: A transfer of length 0 gives a `done` pulse without ever raising `req_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins a transfer; honoured only when idle |
| xfer_len | input | LEN_W | Number of bytes in the burst |
| period | input | PER_W | Negotiated transfer period in 4 ns units |
| offset | input | OFS_W | Negotiated maximum of unacknowledged bytes |
| s_valid | input | 1 | Stream byte available |
| s_ready | output | 1 | Block takes the stream byte this cycle |
| s_data | input | 8 | Stream byte |
| ack_in | input | 1 | Acknowledge strobe from the initiator, asynchronous |
| bus_rst | input | 1 | Bus reset, aborts the transfer |
| bus_data | output | 8 | Data bus value |
| data_oe | output | 1 | Data bus drive enable |
| req_out | output | 1 | Request strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Last transfer ended by bus reset |
| ack_left | output | LEN_W | Acknowledges still owed |

## Verification
Bursts are run with prompt acknowledges at three periods (H of 1, 3 and 5 cycles). These show the strobe widths and the release delay, and they show that byte order is kept even when the stream has gaps. One case withholds every acknowledge, so the sender must stop after exactly the offset count and resume once acknowledges come back. An offset of 0 with prompt acknowledges tells the clamp to 1 apart from a deadlock. A zero-length transfer and a bus reset during a stall cover the transfers that end without data or without completing.

// File: rtl/sync_tx_pkg.sv
`timescale 1ns/1ps
package sync_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HI,
    ST_LO,
    ST_TAIL,
    ST_DRAIN
  } tx_state_t;

  // half of (per * 4 ns) expressed in clock cycles, rounded up, at least one
  function automatic int unsigned half_cycles(int unsigned per, int unsigned clk_ns);
    int unsigned c;
    c = (per * 2 + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/sbt_ack_tracker.sv
`timescale 1ns/1ps
module sbt_ack_tracker #(
  parameter int LEN_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_in,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  output logic [LEN_W-1:0] count
);

  logic [SYNC_N:0] chain;
  logic            fell;

  assign fell = chain[SYNC_N] & ~chain[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      count <= '0;
    end else begin
      chain <= {chain[SYNC_N-1:0], ack_in};
      if (load)
        count <= load_val;
      else if (fell && count != '0)
        count <= count - 1'b1;
    end
  end

  // R2: outside a load the count only falls, one step at a time
  assert_ack_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> count <= $past(count))
    else $error("ack count rose without load");

  assert_ack_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($past(count) - count) <= LEN_W'(1))
    else $error("ack count fell by more than one");

endmodule

// File: rtl/sbt_phase_timer.sv
`timescale 1ns/1ps
module sbt_phase_timer #(
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] len,
  output logic          expired
);

  logic [HW-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= len - 1'b1;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  // R4: a running phase counts down by one each cycle
  assert_phase_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1)
    else $error("phase counter skipped");

endmodule

// File: rtl/sync_burst_tx.sv
`timescale 1ns/1ps
module sync_burst_tx
  import sync_tx_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int PER_W  = 8,
  parameter int OFS_W  = 5,
  parameter int CLK_NS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [PER_W-1:0] period,
  input  logic [OFS_W-1:0] offset,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             ack_in,
  input  logic             bus_rst,
  output logic [7:0]       bus_data,
  output logic             data_oe,
  output logic             req_out,
  output logic             busy,
  output logic             done,
  output logic             aborted,
  output logic [LEN_W-1:0] ack_left
);

  localparam int HW = PER_W + 2;
  localparam int CW = LEN_W + 1;

  tx_state_t        st;
  logic [LEN_W-1:0] to_send;
  logic [OFS_W-1:0] ofs_q;
  logic [HW-1:0]    hcyc_q;
  logic [HW-1:0]    h_new;
  logic [7:0]       data_q;
  logic             req_q, oe_q, done_q, abort_q;
  logic             tmr_exp, tmr_load, trk_load;
  logic [LEN_W-1:0] ack_cnt;
  logic             credit_ok, launch_slot, accept;

  always_comb h_new = HW'(half_cycles(32'(period), CLK_NS));

  // credit: owed acks must fit within bytes-after-this plus offset
  always_comb begin
    credit_ok   = ({1'b0, ack_cnt} <= (CW'(to_send) + CW'(ofs_q) - CW'(1)));
    launch_slot = (to_send != '0) &&
                  ((st == ST_WAIT) || (st == ST_LO && tmr_exp));
    s_ready     = launch_slot && credit_ok && !bus_rst;
    accept      = s_ready && s_valid;
    tmr_load    = accept ||
                  (st == ST_HI && tmr_exp) ||
                  (st == ST_LO && tmr_exp && to_send == '0);
    trk_load    = (st == ST_IDLE) && start && !bus_rst;
  end

  sbt_ack_tracker #(.LEN_W(LEN_W), .SYNC_N(2)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_in   (ack_in),
    .load     (trk_load),
    .load_val (xfer_len),
    .count    (ack_cnt)
  );

  sbt_phase_timer #(.HW(HW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .len     (hcyc_q),
    .expired (tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      to_send <= '0;
      ofs_q   <= OFS_W'(1);
      hcyc_q  <= HW'(1);
      data_q  <= '0;
      req_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (bus_rst && st != ST_IDLE) begin
        st      <= ST_IDLE;
        req_q   <= 1'b0;
        oe_q    <= 1'b0;
        data_q  <= '0;
        abort_q <= 1'b1;
      end else begin
        case (st)
          ST_IDLE: begin
            if (start && !bus_rst) begin
              to_send <= xfer_len;
              ofs_q   <= (offset == '0) ? OFS_W'(1) : offset;
              hcyc_q  <= h_new;
              abort_q <= 1'b0;
              st      <= (xfer_len == '0) ? ST_DRAIN : ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (accept) begin
              data_q  <= s_data;
              req_q   <= 1'b1;
              oe_q    <= 1'b1;
              to_send <= to_send - 1'b1;
              st      <= ST_HI;
            end
          end
          ST_HI: begin
            if (tmr_exp) begin
              req_q <= 1'b0;
              st    <= ST_LO;
            end
          end
          ST_LO: begin
            if (accept) begin
              data_q  <= s_data;
              req_q   <= 1'b1;
              to_send <= to_send - 1'b1;
              st      <= ST_HI;
            end else if (tmr_exp) begin
              st <= (to_send == '0) ? ST_TAIL : ST_WAIT;
            end
          end
          ST_TAIL: begin
            if (tmr_exp) begin
              oe_q   <= 1'b0;
              data_q <= '0;
              st     <= ST_DRAIN;
            end
          end
          ST_DRAIN: begin
            if (ack_cnt == '0) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign bus_data = data_q;
  assign data_oe  = oe_q;
  assign req_out  = req_q;
  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign aborted  = abort_q;
  assign ack_left = ack_cnt;

  // R1: request never asserted without the bus driven
  assert_oe_with_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> oe_q)
    else $error("request without bus drive");

  // R1: data held while request is high
  assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> (!req_q || $stable(data_q)))
    else $error("data moved under request");

  // R3: a new request starts only within the credit window
  assert_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> ({1'b0, ack_cnt} <= CW'(to_send) + CW'(ofs_q)))
    else $error("byte sent beyond offset");

  // R6: completion only with every ack returned
  assert_done_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ack_cnt == '0 && !req_q && !oe_q))
    else $error("done with acks owed");

  // R7: bus reset releases the lines and flags the abort
  assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && st != ST_IDLE) |=> (!req_q && !oe_q && abort_q && !done_q))
    else $error("abort did not release bus");

endmodule

// File: tb/sync_burst_tx_test.sv
`timescale 1ns/1ps
module sync_burst_tx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] xfer_len = '0;
  logic [7:0]  period = '0;
  logic [4:0]  offset = '0;
  logic        s_valid;
  logic        s_ready;
  logic [7:0]  s_data;
  logic        ack_in;
  logic        bus_rst = 1'b0;
  logic [7:0]  bus_data;
  logic        data_oe, req_out, busy, done, aborted;
  logic [15:0] ack_left;

  always #10 clk = ~clk;

  sync_burst_tx #(.LEN_W(16), .PER_W(8), .OFS_W(5), .CLK_NS(20)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
    .period(period), .offset(offset), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .ack_in(ack_in), .bus_rst(bus_rst), .bus_data(bus_data),
    .data_oe(data_oe), .req_out(req_out), .busy(busy), .done(done),
    .aborted(aborted), .ack_left(ack_left)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bus monitor
  int cyc = 0, rises = 0, falls = 0, hi_run = 0, last_hi = 0;
  int fall_cyc = 0, oe_fall_cyc = 0, done_cnt = 0;
  logic [7:0] cap [64];
  logic pr = 1'b0, poe = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (req_out && !pr) begin
      cap[rises % 64] = bus_data;
      rises++;
    end
    if (req_out) hi_run = pr ? hi_run + 1 : 1;
    if (!req_out && pr) begin
      last_hi = hi_run;
      falls++;
      fall_cyc = cyc;
    end
    if (!data_oe && poe) oe_fall_cyc = cyc;
    if (done) done_cnt++;
    pr = req_out;
    poe = data_oe;
  end

  // initiator acknowledge model
  bit ack_en = 0;
  int ack_dly = 1;
  int acks_given = 0;
  initial begin
    ack_in = 1'b0;
    forever begin
      @(posedge clk);
      if (ack_en && acks_given < falls) begin
        repeat (ack_dly) @(posedge clk);
        ack_in <= 1'b1;
        repeat (2) @(posedge clk);
        ack_in <= 1'b0;
        acks_given <= acks_given + 1;
      end
    end
  end

  // stream source
  bit feed_go = 0, gap = 0, took = 0;
  int feed_n = 0, fidx = 0, fc = 0;
  logic [7:0] pat [64];
  initial begin
    s_valid = 1'b0;
    s_data  = '0;
    forever begin
      @(negedge clk);
      fc++;
      if (!feed_go) fidx = 0;
      else if (took) fidx++;
      took = 0;
      if (feed_go && fidx < feed_n && (!gap || (fc % 3) != 0)) begin
        s_valid = 1'b1;
        s_data  = pat[fidx];
      end else begin
        s_valid = 1'b0;
      end
      took = s_valid && s_ready;
    end
  end

  task automatic kick(int len, int per, int ofs);
    @(negedge clk);
    start = 1'b1;
    xfer_len = 16'(len);
    period = 8'(per);
    offset = 5'(ofs);
    feed_go = 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic fill(int len, int per);
    for (int i = 0; i < 64; i++) pat[i] = 8'(i * 37 + len * 5 + per);
    feed_n = len;
  endtask

  task automatic wait_done(int base_d, int limit, input int ofs, output int maxo);
    maxo = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); #2;
      if (rises - acks_given > maxo) maxo = rises - acks_given;
      if (done_cnt > base_d || aborted) break;
    end
  endtask

  task automatic check_data(int base_r, int len, string tag);
    int errs = 0;
    for (int i = 0; i < len; i++)
      if (cap[(base_r + i) % 64] !== pat[i]) errs++;
    chk(errs == 0, tag, errs, 0);
  endtask

  task automatic test_reset();
    @(negedge clk); #2;
    chk(!req_out && !data_oe && !busy && !done && !aborted && ack_left == 0,
        "R6 reset idle outputs", {req_out, data_oe, busy, done, aborted}, 0);
    chk(s_ready == 1'b0, "R8 no ready when idle", s_ready, 0);
  endtask

  task automatic run_burst(int len, int per, int ofs, int dly, bit gp, int exp_h);
    int base_r, base_d, maxo, eff;
    base_r = rises;
    base_d = done_cnt;
    eff = (ofs == 0) ? 1 : ofs;
    fill(len, per);
    gap = gp;
    ack_dly = dly;
    ack_en = 1;
    kick(len, per, ofs);
    wait_done(base_d, 20000, ofs, maxo);
    chk(done_cnt == base_d + 1, "R6 done pulse seen", done_cnt - base_d, 1);
    chk(rises - base_r == len, "R1 request count", rises - base_r, len);
    check_data(base_r, len, gp ? "R8 order with stream gaps" : "R1 data captured on bus");
    chk(last_hi == exp_h, "R4 request high width", last_hi, exp_h);
    chk(oe_fall_cyc - fall_cyc == 2 * exp_h, "R5 release delay",
        oe_fall_cyc - fall_cyc, 2 * exp_h);
    chk(maxo <= eff, "R3 outstanding within offset", maxo, eff);
    chk(ack_left == 0 && !busy, "R2 acks drained", ack_left, 0);
    repeat (4) @(negedge clk);
    #2;
    chk(done_cnt == base_d + 1, "R6 single done pulse", done_cnt - base_d, 1);
    feed_go = 0;
    gap = 0;
  endtask

  task automatic test_stall();
    int base_r, base_d, maxo;
    base_r = rises;
    base_d = done_cnt;
    fill(6, 10);
    ack_en = 0;
    kick(6, 10, 2);
    repeat (200) @(negedge clk);
    #2;
    chk(rises - base_r == 2, "R3 stall at offset", rises - base_r, 2);
    chk(ack_left == 6, "R2 count loaded with length", ack_left, 6);
    chk(done_cnt == base_d && busy, "R6 no done while acks owed", done_cnt - base_d, 0);
    ack_dly = 0;
    ack_en = 1;
    wait_done(base_d, 20000, 2, maxo);
    chk(rises - base_r == 6 && done_cnt == base_d + 1, "R3 resumes after acks",
        rises - base_r, 6);
    check_data(base_r, 6, "R3 data after stall");
    chk(ack_left == 0, "R2 count reaches zero", ack_left, 0);
    feed_go = 0;
  endtask

  task automatic test_zero();
    int base_r, base_d, maxo;
    base_r = rises;
    base_d = done_cnt;
    feed_n = 0;
    kick(0, 25, 4);
    wait_done(base_d, 50, 4, maxo);
    chk(done_cnt == base_d + 1, "R9 zero length done", done_cnt - base_d, 1);
    chk(rises == base_r, "R9 no request for zero length", rises - base_r, 0);
    feed_go = 0;
  endtask

  task automatic test_abort();
    int base_r, base_d;
    base_r = rises;
    base_d = done_cnt;
    fill(10, 10);
    ack_en = 0;
    kick(10, 10, 3);
    repeat (100) @(negedge clk);
    #2;
    chk(rises - base_r == 3, "R3 stall before abort", rises - base_r, 3);
    @(negedge clk);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    #2;
    chk(!req_out && !data_oe && !busy, "R7 lines released", {req_out, data_oe, busy}, 0);
    chk(aborted == 1'b1, "R7 abort flag", aborted, 1);
    chk(ack_left == 10, "R7 residual ack count", ack_left, 10);
    feed_go = 0;
    repeat (20) @(negedge clk);
    #2;
    chk(done_cnt == base_d && aborted, "R7 no done after abort", done_cnt - base_d, 0);
    chk(ack_left == 10, "R7 residual count holds", ack_left, 10);
    feed_n = 0;
    kick(0, 10, 3);
    #2;
    chk(aborted == 1'b0, "R7 flag cleared by start", aborted, 0);
    feed_go = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_burst(8, 25, 4, 1, 0, 3);
    run_burst(12, 0, 15, 0, 1, 1);
    run_burst(5, 50, 0, 2, 0, 5);
    test_stall();
    test_zero();
    test_abort();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule